// File: doc/BRIEF.md
# Epoch-Based Fetch Redirect Controller

This block steers the front end of a two-stage pipeline whose first stage fetches and decodes and whose second stage executes. It owns the program counter and two one-bit epoch flags, one on the fetch side and one on the execute side. Each cycle it decides whether the decoded instruction moves into the decode-to-execute queue. When a hazard is flagged it holds back, and when execute has reported a wrong branch prediction it steers fetch to the corrected address instead.

Wrong-path work is never flushed. Each instruction carries the fetch epoch it was issued under. Execute compares that tag with its own epoch and discards any instruction whose tag is stale, with no side effects. A mispredict inverts the execute epoch and parks the corrected target in a one-entry holding register. On the next cycle fetch takes the target, inverts its own epoch and issues nothing. The predicted next address is always the current pc plus a fixed step. The pc moves to it only when the queue accepts the instruction.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While and after reset, the pc equals the parameter PC_RESET, both epoch flags are 0 and no redirect is pending.
- R2: With no redirect pending and the stall input low, iss_valid_o is 1 whatever iss_ready_i is. iss_pc_o is the pc, iss_ppc_o is pc + PC_STEP and iss_epoch_o is the fetch epoch.
- R3: While hz_stall_i is 1, iss_valid_o and sb_insert_o are 0 and the pc keeps its value.
- R4: The pc becomes pc + PC_STEP on an edge where iss_valid_o and iss_ready_i were both 1. It holds its value on any other edge without a redirect.
- R5: An instruction at execute (ex_valid_i = 1) whose ex_epoch_i equals the execute epoch and that reports ex_mispredict_i = 1 inverts the execute epoch at the next edge and records ex_target_i as a pending redirect.
- R6: In a cycle with a redirect pending, iss_valid_o is 0 even when the stall input is low. At the following edge the pc loads the recorded target and the fetch epoch inverts. If a new mispredict is accepted in that same cycle, its target is recorded as the next pending redirect.
- R7: An instruction at execute whose ex_epoch_i differs from the execute epoch raises ex_drop_o in that cycle. Its mispredict flag has no effect: the execute epoch and the fetch side are unchanged.
- R8: ex_release_o equals ex_valid_i in every cycle, whether or not the instruction is dropped. ex_mispredict_i with ex_valid_i = 0 has no effect.
- R9: sb_insert_o is 1 exactly in cycles where iss_valid_o and iss_ready_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hz_stall_i | input | 1 | Hazard check result for the decoded instruction |
| iss_ready_i | input | 1 | Decode-to-execute queue can accept |
| iss_valid_o | output | 1 | Instruction offered to execute |
| iss_pc_o | output | ADDR_W | Pc of the offered instruction (also the fetch address) |
| iss_ppc_o | output | ADDR_W | Predicted next pc |
| iss_epoch_o | output | 1 | Fetch epoch carried by the instruction |
| sb_insert_o | output | 1 | Scoreboard insert strobe |
| ex_valid_i | input | 1 | An instruction is leaving execute this cycle |
| ex_epoch_i | input | 1 | Epoch tag of that instruction |
| ex_mispredict_i | input | 1 | Execute found the prediction wrong |
| ex_target_i | input | ADDR_W | Corrected next pc |
| ex_drop_o | output | 1 | Instruction is stale; suppress its effects |
| ex_release_o | output | 1 | Scoreboard release strobe |
| exec_epoch_o | output | 1 | Current execute epoch |

## Verification
The hardest case to reach is a second mispredict that execute accepts in the very cycle fetch is using up a pending redirect. It only happens when an instruction carrying the already-inverted epoch reaches execute before the redirect is taken. Wrong-path tags would not allow this. The bench reaches it by driving the execute tag from its own model of the execute epoch rather than from issued instructions. It then checks that the second target is taken one cycle after the first. Stall cycles, queue back-pressure and stale reports are mixed in with the redirects, so that every ordering of hold, advance and redirect is seen.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    FA_IDLE     = 2'd0,
    FA_REDIRECT = 2'd1,
    FA_ISSUE    = 2'd2
  } fetch_act_e;

  function automatic logic tag_stale(input logic tag, input logic cur);
    return tag != cur;
  endfunction

endpackage

// File: rtl/frc_redirect_hold.sv
module frc_redirect_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_tgt_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] tgt_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      tgt_o  <= '0;
    end else if (load_i) begin
      pend_o <= 1'b1;
      tgt_o  <= load_tgt_i;
    end else if (take_i) begin
      pend_o <= 1'b0;
    end
  end

endmodule

// File: rtl/frc_exec_epoch.sv
module frc_exec_epoch (
  input  logic clk,
  input  logic rst,
  input  logic ex_valid_i,
  input  logic ex_epoch_i,
  input  logic ex_mispredict_i,
  output logic eepoch_o,
  output logic drop_o,
  output logic redir_o,
  output logic release_o
);
  import frc_pkg::*;

  always_comb begin
    drop_o    = ex_valid_i && tag_stale(ex_epoch_i, eepoch_o);
    redir_o   = ex_valid_i && !drop_o && ex_mispredict_i;
    release_o = ex_valid_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          eepoch_o <= 1'b0;
    else if (redir_o) eepoch_o <= ~eepoch_o;
  end

endmodule

// File: rtl/frc_fetch_pc.sv
module frc_fetch_pc #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PC_RESET = '0,
  parameter int                PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_pend_i,
  input  logic [ADDR_W-1:0] redir_tgt_i,
  input  logic              stall_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ppc_o,
  output logic              fepoch_o,
  output logic              valid_o,
  output logic              fire_o,
  output logic              take_o
);
  import frc_pkg::*;

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PC_STEP);

  fetch_act_e act;

  always_comb begin
    if (redir_pend_i)  act = FA_REDIRECT;
    else if (!stall_i) act = FA_ISSUE;
    else               act = FA_IDLE;
    ppc_o   = pc_o + STEP_V;
    valid_o = (act == FA_ISSUE);
    fire_o  = valid_o && ready_i;
    take_o  = (act == FA_REDIRECT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= PC_RESET;
      fepoch_o <= 1'b0;
    end else if (take_o) begin
      pc_o     <= redir_tgt_i;
      fepoch_o <= ~fepoch_o;
    end else if (fire_o) begin
      pc_o     <= ppc_o;
    end
  end

endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PC_RESET = '0,
  parameter int                PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hz_stall_i,
  input  logic              iss_ready_i,
  output logic              iss_valid_o,
  output logic [ADDR_W-1:0] iss_pc_o,
  output logic [ADDR_W-1:0] iss_ppc_o,
  output logic              iss_epoch_o,
  output logic              sb_insert_o,
  input  logic              ex_valid_i,
  input  logic              ex_epoch_i,
  input  logic              ex_mispredict_i,
  input  logic [ADDR_W-1:0] ex_target_i,
  output logic              ex_drop_o,
  output logic              ex_release_o,
  output logic              exec_epoch_o
);

  logic              redir_pend;
  logic [ADDR_W-1:0] redir_tgt;
  logic              redir_take;
  logic              redir_new;

  frc_exec_epoch u_exec (
    .clk            (clk),
    .rst            (rst),
    .ex_valid_i     (ex_valid_i),
    .ex_epoch_i     (ex_epoch_i),
    .ex_mispredict_i(ex_mispredict_i),
    .eepoch_o       (exec_epoch_o),
    .drop_o         (ex_drop_o),
    .redir_o        (redir_new),
    .release_o      (ex_release_o)
  );

  frc_redirect_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load_i    (redir_new),
    .load_tgt_i(ex_target_i),
    .take_i    (redir_take),
    .pend_o    (redir_pend),
    .tgt_o     (redir_tgt)
  );

  frc_fetch_pc #(
    .ADDR_W  (ADDR_W),
    .PC_RESET(PC_RESET),
    .PC_STEP (PC_STEP)
  ) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .redir_pend_i(redir_pend),
    .redir_tgt_i (redir_tgt),
    .stall_i     (hz_stall_i),
    .ready_i     (iss_ready_i),
    .pc_o        (iss_pc_o),
    .ppc_o       (iss_ppc_o),
    .fepoch_o    (iss_epoch_o),
    .valid_o     (iss_valid_o),
    .fire_o      (sb_insert_o),
    .take_o      (redir_take)
  );

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] PC_RESET = '0,
  parameter int                PC_STEP  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hz_stall_i,
  input logic              iss_ready_i,
  input logic              iss_valid_o,
  input logic [ADDR_W-1:0] iss_pc_o,
  input logic              iss_epoch_o,
  input logic              sb_insert_o,
  input logic              ex_valid_i,
  input logic              ex_drop_o,
  input logic              ex_release_o,
  input logic              exec_epoch_o,
  input logic              redir_pend
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PC_STEP);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iss_pc_o == PC_RESET && !iss_epoch_o && !exec_epoch_o && !redir_pend));

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    hz_stall_i |-> (!iss_valid_o && !sb_insert_o));

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!(iss_valid_o && iss_ready_i) && !redir_pend) |=> $stable(iss_pc_o));

  p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_valid_o && iss_ready_i) |=> (iss_pc_o == $past(iss_pc_o) + STEP_V));

  p_redirect_flip_r6: assert property (@(posedge clk) disable iff (rst)
    redir_pend |=> (iss_epoch_o != $past(iss_epoch_o)));

  p_redirect_no_issue_r6: assert property (@(posedge clk) disable iff (rst)
    redir_pend |-> !iss_valid_o);

  p_stale_keeps_epoch_r7: assert property (@(posedge clk) disable iff (rst)
    ex_drop_o |=> $stable(exec_epoch_o));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    ex_release_o == ex_valid_i);

  p_insert_r9: assert property (@(posedge clk) disable iff (rst)
    sb_insert_o == (iss_valid_o && iss_ready_i));

endmodule

bind fetch_redirect_ctrl frc_checker #(
  .ADDR_W  (ADDR_W),
  .PC_RESET(PC_RESET),
  .PC_STEP (PC_STEP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hz_stall_i  (hz_stall_i),
  .iss_ready_i (iss_ready_i),
  .iss_valid_o (iss_valid_o),
  .iss_pc_o    (iss_pc_o),
  .iss_epoch_o (iss_epoch_o),
  .sb_insert_o (sb_insert_o),
  .ex_valid_i  (ex_valid_i),
  .ex_drop_o   (ex_drop_o),
  .ex_release_o(ex_release_o),
  .exec_epoch_o(exec_epoch_o),
  .redir_pend  (redir_pend)
);

// File: tb/fetch_redirect_ctrl_tb.sv
module fetch_redirect_ctrl_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam logic [31:0] RST_PC     = 32'h0000_1000;
  localparam int          NVEC       = 16;

  // vector: {stall, ready, ex_valid, tag_matches, mispredict, target[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h2000},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h3000},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0044},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0080},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h5000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hz_stall_i = 1'b0;
  logic          iss_ready_i = 1'b0;
  logic          ex_valid_i = 1'b0;
  logic          ex_epoch_i = 1'b0;
  logic          ex_mispredict_i = 1'b0;
  logic [AW-1:0] ex_target_i = '0;
  logic          iss_valid_o, iss_epoch_o, sb_insert_o;
  logic [AW-1:0] iss_pc_o, iss_ppc_o;
  logic          ex_drop_o, ex_release_o, exec_epoch_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [31:0] m_pc;
  logic        m_fe, m_ee, m_pend;
  logic [31:0] m_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_redirect_ctrl #(.ADDR_W(AW), .PC_RESET(RST_PC), .PC_STEP(4)) u_dut (
    .clk(clk), .rst(rst), .hz_stall_i(hz_stall_i), .iss_ready_i(iss_ready_i),
    .iss_valid_o(iss_valid_o), .iss_pc_o(iss_pc_o), .iss_ppc_o(iss_ppc_o),
    .iss_epoch_o(iss_epoch_o), .sb_insert_o(sb_insert_o), .ex_valid_i(ex_valid_i),
    .ex_epoch_i(ex_epoch_i), .ex_mispredict_i(ex_mispredict_i), .ex_target_i(ex_target_i),
    .ex_drop_o(ex_drop_o), .ex_release_o(ex_release_o), .exec_epoch_o(exec_epoch_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = RST_PC; m_fe = 1'b0; m_ee = 1'b0; m_pend = 1'b0; m_tgt = '0;
  endtask

  task automatic run_vec(input logic [20:0] v);
    logic st, rd, xv, mt, mp, exp_valid, exp_drop, fire, acc;
    logic [31:0] tg;
    {st, rd, xv, mt, mp} = v[20:16];
    tg = {16'h0000, v[15:0]};
    @(negedge clk);
    hz_stall_i = st; iss_ready_i = rd; ex_valid_i = xv;
    ex_epoch_i = mt ? m_ee : ~m_ee; ex_mispredict_i = mp; ex_target_i = tg;
    #(CLK_PERIOD/4);
    exp_valid = !m_pend && !st;
    exp_drop  = xv && !mt;
    fire      = exp_valid && rd;
    acc       = xv && mt && mp;
    check(st ? "R3 valid under stall" : (m_pend ? "R6 no issue on redirect" : "R2 valid"),
          32'(iss_valid_o), 32'(exp_valid));
    check("R4 pc", iss_pc_o, m_pc);
    check("R2 ppc", iss_ppc_o, m_pc + 32'd4);
    check("R6 fetch epoch", 32'(iss_epoch_o), 32'(m_fe));
    check("R5 exec epoch", 32'(exec_epoch_o), 32'(m_ee));
    check("R7 drop", 32'(ex_drop_o), 32'(exp_drop));
    check("R8 release", 32'(ex_release_o), 32'(xv));
    check("R9 insert", 32'(sb_insert_o), 32'(fire));
    if (m_pend) begin
      m_pc = m_tgt; m_fe = ~m_fe; m_pend = 1'b0;
    end else if (fire) begin
      m_pc = m_pc + 32'd4;
    end
    if (acc) begin
      m_ee = ~m_ee; m_pend = 1'b1; m_tgt = tg;
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 pc in reset", iss_pc_o, RST_PC);
    check("R1 epochs in reset", 32'({iss_epoch_o, exec_epoch_o}), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);
    // after table: the second redirect (0x80) was taken right after the first
    @(negedge clk);
    hz_stall_i = 1'b1; ex_valid_i = 1'b0; ex_mispredict_i = 1'b0;
    #(CLK_PERIOD/4);
    check("R4 pc after run", iss_pc_o, m_pc);
    // mid-run reset returns to the reset state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model_reset();
    #(CLK_PERIOD/4);
    check("R1 pc after reset", iss_pc_o, RST_PC);
    check("R1 fetch epoch after reset", 32'(iss_epoch_o), 32'd0);
    check("R1 exec epoch after reset", 32'(exec_epoch_o), 32'd0);
    // R6 back-to-back redirect: mispredict then issue resumes at target
    run_vec({1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0600});
    run_vec({1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000});
    run_vec({1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000});
    check("R6 resumed at target", m_pc, 32'h0000_0604);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule